// File: doc/BRIEF.md
# I2C ADC Conversion Sequencer

This block is the digital side of an 8-bit analog-to-digital converter that sits on an I2C bus. It watches SCL and SDA for a START, collects the seven address bits and the read/write bit of the first byte, and drives the track/hold control. When the address matches, it runs a successive-approximation conversion. The conversion asks an outside comparator one question per bit and returns an 8-bit result with a one-cycle valid pulse.

The mode input is sampled at START and picks one of two timings. In external clock mode the track window and every conversion step are tied to SCL falling edges. Track starts on the 7th falling edge of a matching address byte, and hold starts on the 8th. The next eight SCL falling edges each resolve one bit. In internal clock mode the block makes its own conversion clock by dividing the system clock. At the 8th falling edge it enters track and pulls SCL low. Two internal clock periods later it enters hold and resolves one bit per internal period. It releases SCL when the result is presented.

Top module: `i2c_adc_seq`

## Requirements
- R1: After reset, th_track_o, scl_pd_o, cnv_strobe_o and result_vld_o are all low.
- R2: In external clock mode, th_track_o goes high after the 7th SCL falling edge that follows a bit sampled on a rising edge, but only if the seven address bits (MSB first) equal DEV_ADDR.
- R3: In external clock mode, th_track_o falls (hold) after the 8th SCL falling edge. Each of the next eight SCL falling edges resolves one bit and gives one cnv_strobe_o pulse, eight pulses in all.
- R4: In internal clock mode, th_track_o rises after the 8th SCL falling edge of a matching byte. It stays high for exactly 2*INT_DIV system clocks, which is two internal clock periods.
- R5: In internal clock mode, the eight cnv_strobe_o pulses are spaced exactly INT_DIV system clocks apart.
- R6: scl_pd_o is asserted only in internal clock mode. It rises after the 8th SCL falling edge, stays high through the conversion, and falls in the same cycle that result_vld_o rises.
- R7: Bits resolve MSB first. trial_o is the bits already resolved with the current bit set to 1. A comparator input of 1 keeps that bit, so result_o equals the largest code the comparator accepts.
- R8: result_vld_o is a single-cycle pulse that comes exactly INT_DIV system clocks after the last cnv_strobe_o pulse, in both modes.
- R9: An address that does not match DEV_ADDR returns the block to idle. It gives no track, no strobe and no valid pulse.
- R10: A STOP during the address byte returns the block to idle without entering track, and a later matching transaction converts normally.
- R11: mode_int_i is captured at START. Changing it later in the transaction has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| mode_int_i | input | 1 | 1 = internal clock mode, 0 = external clock mode; sampled at START |
| cmp_i | input | 1 | Comparator answer: 1 when the input is at or above trial_o |
| scl_pd_o | output | 1 | SCL pull-down enable (clock stretch) |
| th_track_o | output | 1 | 1 = track, 0 = hold |
| cnv_strobe_o | output | 1 | One-cycle pulse per resolved bit |
| trial_o | output | RES_W | Trial code shown to the comparator |
| result_o | output | RES_W | Conversion result |
| result_vld_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
A wrong address-byte count or a wrong compare shows up at th_track_o within one SCL half period of the 7th or 8th falling edge. Either track never rises, or it rises on the wrong edge. A fault in the internal divider or the acquisition counter changes the measured track width and the strobe spacing by whole INT_DIV steps. A fault in the SAR register shows up only at result_vld_o, as a wrong code or a strobe count other than eight. So each conversion is scored against the bench's model value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_EXT_TRK,
    ST_EXT_CNV,
    ST_INT_ACQ,
    ST_INT_CNV,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign scl_rise  = ~scl_q & scl_sync[1];
  assign scl_fall  = scl_q & ~scl_sync[1];
  assign start_det = scl_q & scl_sync[1] & sda_q & ~sda_sync[1];
  assign stop_det  = scl_q & scl_sync[1] & ~sda_q & sda_sync[1];
endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= tick ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         step,
  input  logic         cmp,
  output logic [W-1:0] trial,
  output logic [W-1:0] acc,
  output logic         strobe,
  output logic         last
);
  localparam int IW = $clog2(W);
  logic [IW-1:0] idx;
  logic [W-1:0]  bitm, nacc;

  assign bitm = W'(1) << idx;
  assign nacc = acc | (cmp ? bitm : '0);
  assign last = (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      acc    <= '0;
      trial  <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (init) begin
        idx   <= IW'(W - 1);
        acc   <= '0;
        trial <= W'(1) << (W - 1);
      end else if (step) begin
        acc    <= nacc;
        trial  <= last ? nacc : (nacc | (bitm >> 1));
        idx    <= idx - IW'(1);
        strobe <= 1'b1;
      end
    end
  end

  a_r7_idx_walks_down: assert property (@(posedge clk) disable iff (rst)
    (step && !init && !last) |=> (idx == $past(idx) - IW'(1)));
  a_r7_init_msb: assert property (@(posedge clk) disable iff (rst)
    init |=> (trial[W-1] && acc == '0));
endmodule

// File: rtl/i2c_adc_seq.sv
module i2c_adc_seq
  import adc_seq_pkg::*;
#(
  parameter int         RES_W    = 8,
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         INT_DIV  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             mode_int_i,
  input  logic             cmp_i,
  output logic             scl_pd_o,
  output logic             th_track_o,
  output logic             cnv_strobe_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_vld_o
);
  localparam int ADDR_W = 7;
  localparam int CNT_W  = 4;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic tick, tick_en, tick_clr;
  logic sar_init, sar_step, sar_last;
  logic [RES_W-1:0] sar_acc;

  seq_st_e state, state_n;
  logic [CNT_W-1:0]  rise_cnt, fall_cnt;
  logic [ADDR_W-1:0] sreg;
  logic mode_q, match_q, acq_cnt;
  logic bit_fall, addr_hit;

  i2c_line_mon u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  adc_tick_gen #(.DIV(INT_DIV)) u_tick (
    .clk(clk), .rst(rst), .en(tick_en), .clr(tick_clr), .tick(tick)
  );

  adc_sar #(.W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .init(sar_init), .step(sar_step), .cmp(cmp_i),
    .trial(trial_o), .acc(sar_acc), .strobe(cnv_strobe_o), .last(sar_last)
  );

  assign bit_fall = scl_fall && (rise_cnt > fall_cnt);
  assign addr_hit = (sreg == DEV_ADDR);
  assign tick_en  = (state == ST_INT_ACQ) || (state == ST_INT_CNV) || (state == ST_DONE);
  assign tick_clr = (state_n != state);

  always_comb begin
    state_n  = state;
    sar_init = 1'b0;
    sar_step = 1'b0;
    unique case (state)
      ST_IDLE: if (start_det) state_n = ST_ADDR;
      ST_ADDR: begin
        if (stop_det) state_n = ST_IDLE;
        else if (bit_fall && fall_cnt == CNT_W'(6)) begin
          if (!addr_hit)    state_n = ST_IDLE;
          else if (!mode_q) state_n = ST_EXT_TRK;
        end else if (bit_fall && fall_cnt == CNT_W'(7)) begin
          state_n = ST_INT_ACQ;
        end
      end
      ST_EXT_TRK: begin
        if (stop_det || start_det) state_n = ST_IDLE;
        else if (scl_fall) begin
          state_n  = ST_EXT_CNV;
          sar_init = 1'b1;
        end
      end
      ST_EXT_CNV: begin
        if (stop_det || start_det) state_n = ST_IDLE;
        else if (scl_fall) begin
          sar_step = 1'b1;
          if (sar_last) state_n = ST_DONE;
        end
      end
      ST_INT_ACQ: if (tick && acq_cnt) begin
        state_n  = ST_INT_CNV;
        sar_init = 1'b1;
      end
      ST_INT_CNV: if (tick) begin
        sar_step = 1'b1;
        if (sar_last) state_n = ST_DONE;
      end
      ST_DONE: if (tick) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      rise_cnt     <= '0;
      fall_cnt     <= '0;
      sreg         <= '0;
      mode_q       <= 1'b0;
      match_q      <= 1'b0;
      acq_cnt      <= 1'b0;
      th_track_o   <= 1'b0;
      scl_pd_o     <= 1'b0;
      result_o     <= '0;
      result_vld_o <= 1'b0;
    end else begin
      state <= state_n;
      if (start_det && (state == ST_IDLE || state == ST_ADDR)) begin
        rise_cnt <= '0;
        fall_cnt <= '0;
        sreg     <= '0;
        match_q  <= 1'b0;
        mode_q   <= mode_int_i;
      end else if (state == ST_ADDR) begin
        if (scl_rise) begin
          rise_cnt <= rise_cnt + CNT_W'(1);
          if (rise_cnt < CNT_W'(ADDR_W)) sreg <= {sreg[ADDR_W-2:0], sda_i};
        end
        if (bit_fall) begin
          fall_cnt <= fall_cnt + CNT_W'(1);
          if (fall_cnt == CNT_W'(6)) match_q <= addr_hit;
        end
      end
      if (tick_clr)                         acq_cnt <= 1'b0;
      else if (state == ST_INT_ACQ && tick) acq_cnt <= 1'b1;
      th_track_o   <= (state_n == ST_EXT_TRK) || (state_n == ST_INT_ACQ);
      scl_pd_o     <= mode_q && ((state_n == ST_INT_ACQ) || (state_n == ST_INT_CNV) ||
                                 (state_n == ST_DONE));
      result_vld_o <= (state == ST_DONE) && tick;
      if ((state == ST_DONE) && tick) result_o <= sar_acc;
    end
  end

  a_r9_track_needs_match: assert property (@(posedge clk) disable iff (rst)
    $rose(th_track_o) |-> match_q);
  a_r6_pd_only_internal: assert property (@(posedge clk) disable iff (rst)
    scl_pd_o |-> mode_q);
  a_r8_vld_single: assert property (@(posedge clk) disable iff (rst)
    result_vld_o |=> !result_vld_o);
  a_r3_no_strobe_in_track: assert property (@(posedge clk) disable iff (rst)
    cnv_strobe_o |-> !th_track_o);
  a_r6_release_with_vld: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_pd_o) |-> result_vld_o);
endmodule

// File: tb/test_i2c_adc_seq.sv
module test_i2c_adc_seq;
  localparam int         W    = 8;
  localparam int         DIV  = 8;
  localparam logic [6:0] ADDR = 7'h34;
  localparam int         HP   = 12;

  typedef struct packed { logic [W-1:0] code; logic intm; } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1, mode_int = 1'b0;
  logic [W-1:0] analog = '0;
  wire scl_line;
  logic scl_pd, th_track, strobe, vld, cmp;
  logic [W-1:0] trial, result;

  always #10 clk = ~clk;

  assign scl_line = scl_drv & ~scl_pd;
  assign cmp      = (analog >= trial);

  i2c_adc_seq #(.RES_W(W), .DEV_ADDR(ADDR), .INT_DIV(DIV)) i_i2c_adc_seq (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_drv),
    .mode_int_i(mode_int), .cmp_i(cmp), .scl_pd_o(scl_pd),
    .th_track_o(th_track), .cnv_strobe_o(strobe), .trial_o(trial),
    .result_o(result), .result_vld_o(vld)
  );

  int n_chk = 0, n_bad = 0;
  item_t exp_q[$];
  int cyc = 0, vld_cnt = 0, track_rises = 0, strobe_total = 0;

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; scl_drv = 1'b1; wait_clk(HP);
    sda_drv = 1'b0; wait_clk(HP);
    scl_drv = 1'b0; wait_clk(HP);
  endtask

  task automatic i2c_bit(input logic b);
    sda_drv = b; wait_clk(HP);
    scl_drv = 1'b1; wait_clk(HP);
    scl_drv = 1'b0;
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; wait_clk(HP);
    scl_drv = 1'b1; wait_clk(HP);
    sda_drv = 1'b1; wait_clk(HP);
  endtask

  // External mode transaction with track/hold checks at the pins.
  task automatic ext_conv(input logic [W-1:0] code);
    logic [7:0] byt;
    byt = {ADDR, 1'b1};
    analog = code;
    exp_q.push_back('{code: code, intm: 1'b0});
    mode_int = 1'b0;
    i2c_start();
    for (int i = 7; i >= 2; i--) i2c_bit(byt[i]);
    wait_clk(4);
    check("R2 track low before 7th fall", int'(th_track), 0);
    i2c_bit(byt[1]);               // 7th falling edge
    sda_drv = byt[0]; wait_clk(HP);
    check("R2 track after 7th fall", int'(th_track), 1);
    scl_drv = 1'b1; wait_clk(HP);
    scl_drv = 1'b0; wait_clk(6);   // 8th falling edge
    check("R3 hold after 8th fall", int'(th_track), 0);
    for (int i = 0; i < 8; i++) i2c_bit(1'b1);
    wait_clk(DIV + 8);
    i2c_stop();
  endtask

  // Internal mode transaction; optionally flips mode right after START.
  task automatic int_conv(input logic [W-1:0] code, input logic flip);
    logic [7:0] byt;
    int v0;
    byt = {ADDR, 1'b1};
    analog = code;
    exp_q.push_back('{code: code, intm: 1'b1});
    mode_int = 1'b1;
    v0 = vld_cnt;
    i2c_start();
    if (flip) mode_int = 1'b0;
    for (int i = 7; i >= 1; i--) i2c_bit(byt[i]);
    wait_clk(4);
    check("R4 no track before 8th fall (internal)", int'(th_track), 0);
    i2c_bit(byt[0]);
    wait_clk(6);
    check(flip ? "R11 stretch despite late mode change" : "R6 stretch after 8th fall",
          int'(scl_pd), 1);
    scl_drv = 1'b1;
    for (int k = 0; k < 2000 && vld_cnt == v0; k++) wait_clk(1);
    wait_clk(4);
    check("R6 SCL released after result", int'(scl_line), 1);
    scl_drv = 1'b0; wait_clk(HP);
    i2c_stop();
    mode_int = 1'b0;
  endtask

  // Monitor / scoreboard
  int t_rise = 0, t_width = 0, n_str = 0, last_str = 0, gmin = 0, gmax = 0;
  logic pd_seen = 1'b0, pd_prev = 1'b0, trk_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (th_track && !trk_prev) begin t_rise = cyc; track_rises++; end
      if (!th_track && trk_prev) t_width = cyc - t_rise;
      if (scl_pd) pd_seen = 1'b1;
      if (strobe) begin
        if (n_str > 0) begin
          if (n_str == 1 || cyc - last_str < gmin) gmin = cyc - last_str;
          if (n_str == 1 || cyc - last_str > gmax) gmax = cyc - last_str;
        end
        n_str++; last_str = cyc; strobe_total++;
      end
      if (vld) begin
        item_t it;
        vld_cnt++;
        if (exp_q.size() == 0) begin
          check("R9 unexpected result_vld", 1, 0);
        end else begin
          it = exp_q.pop_front();
          check("R7 result code", int'(result), int'(it.code));
          check("R3 strobes per conversion", n_str, 8);
          check("R8 vld delay after last strobe", cyc - last_str, DIV);
          check("R11 stretch matches captured mode", int'(pd_seen), int'(it.intm));
          if (it.intm) begin
            check("R4 track width", t_width, 2 * DIV);
            check("R5 min strobe spacing", gmin, DIV);
            check("R5 max strobe spacing", gmax, DIV);
            check("R6 pd falls with vld", int'({pd_prev, scl_pd}), 2);
          end
        end
        n_str = 0; pd_seen = 1'b0;
      end
      if (vld) pd_seen = 1'b0;
    end
    pd_prev  = scl_pd;
    trk_prev = th_track;
  end

  initial begin
    int tr0, st0, v0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    check("R1 track reset", int'(th_track), 0);
    check("R1 pull-down reset", int'(scl_pd), 0);
    check("R1 strobe reset", int'(strobe), 0);
    check("R1 valid reset", int'(vld), 0);

    ext_conv(8'hA5);
    ext_conv(8'hFF);
    int_conv(8'h00, 1'b0);
    int_conv(8'h5A, 1'b1);

    // R9: wrong address
    tr0 = track_rises; st0 = strobe_total; v0 = vld_cnt;
    mode_int = 1'b0;
    i2c_start();
    for (int i = 7; i >= 0; i--) i2c_bit(i[0]);
    for (int i = 0; i < 8; i++) i2c_bit(1'b1);
    wait_clk(DIV + 8);
    i2c_stop();
    check("R9 no track on mismatch", track_rises - tr0, 0);
    check("R9 no strobe on mismatch", strobe_total - st0, 0);
    check("R9 no vld on mismatch", vld_cnt - v0, 0);

    // R10: STOP in the middle of the address byte
    tr0 = track_rises;
    i2c_start();
    i2c_bit(ADDR[6]); i2c_bit(ADDR[5]); i2c_bit(ADDR[4]);
    i2c_stop();
    for (int i = 0; i < 10; i++) i2c_bit(1'b1);
    wait_clk(HP);
    check("R10 no track after mid-byte STOP", track_rises - tr0, 0);
    scl_drv = 1'b1; wait_clk(HP);
    ext_conv(8'h3C);

    wait_clk(40);
    check("R3 all conversions scored", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule